// File: doc/BRIEF.md
# Superimposition Key Signal Generator

This block decides, for every pixel, whether the locally generated graphics or an external video source reaches the screen. From the current pixel colour and a small set of mode controls it forms a one-bit key (high: show graphics, low: show external video). Alongside the key it forms a six-bit transparency code. The two are then delayed by a programmable number of pixel clocks so they line up with the video path downstream.

Three keying rules are available. The first compares each pixel against the border colour. The second compares each pixel against a chroma-key colour. The third applies no comparison and drives a fixed fill level taken from a mode bit. The transparency code comes from a per-pixel value, or from a separate value for background pixels, and can be forced to zero. Colour lookup, video encoding and burst generation sit outside this block.

Top module: `sup_key_gen`

## Requirements
- R1: While `sup_en_i` is low, the undelayed key is 1, whatever the mode and colours.
- R2: With `sup_en_i` high and {`cmp_e_i`,`cmp_f_i`} equal to 00 or 10, the undelayed key equals `fill_g_i`.
- R3: With `sup_en_i` high, `cmp_e_i`=0, `cmp_f_i`=1 and `border_rgb_i` not equal to 12'h000, the undelayed key is 1 when `pix_rgb_i` differs from `border_rgb_i`, and 0 when they are equal.
- R4: With `sup_en_i` high, `cmp_e_i`=0, `cmp_f_i`=1 and `border_rgb_i` equal to 12'h000 (black), the undelayed key equals `fill_g_i`.
- R5: With `sup_en_i` high and `cmp_e_i`=`cmp_f_i`=1, the undelayed key is 1 when `pix_rgb_i` differs from `chroma_rgb_i`, and 0 when they are equal.
- R6: With `trans_en_i` low, the undelayed transparency code is 6'h00 (full display), whatever `pix_trans_i`, `bg_trans_i` and `pix_is_bg_i` hold.
- R7: With `trans_en_i` high, the undelayed transparency code is `bg_trans_i` when `pix_is_bg_i` is 1, and `pix_trans_i` otherwise.
- R8: With a delay setting N in force (0 to 7), `key_o` and `trans_o` show the undelayed key and code formed from the inputs N clock cycles earlier. N=0 is a combinational path.
- R9: During reset and right after it, every pipeline stage holds key 1 and code 0, and the delay in force is 1. So `key_o`=1 and `trans_o`=0 until new values reach the selected stage.
- R10: `dly_i` is sampled at each rising clock edge. A new setting governs the outputs only from the edge that samples it onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sup_en_i | input | 1 | Superimpose enable |
| cmp_e_i | input | 1 | Comparison mode bit E |
| cmp_f_i | input | 1 | Comparison mode bit F |
| fill_g_i | input | 1 | Fill level used when no comparison applies |
| pix_rgb_i | input | 12 | Current pixel colour, 4 bits per component |
| border_rgb_i | input | 12 | Border colour |
| chroma_rgb_i | input | 12 | Chroma-key colour |
| trans_en_i | input | 1 | Transparency enable |
| pix_is_bg_i | input | 1 | Current pixel is background |
| pix_trans_i | input | 6 | Per-pixel transparency code |
| bg_trans_i | input | 6 | Background transparency code |
| dly_i | input | 3 | Output delay setting, 0 to 7 clocks |
| key_o | output | 1 | Delayed key, 1 = graphics shown |
| trans_o | output | 6 | Delayed transparency code |

## Verification
The bench drives every input just after a falling edge and samples 1 ns later. At that point an output under delay N reflects the values driven N falling edges earlier, and delay 0 reflects the values just driven. For the combinational rules (R1 to R7) the delay is first set to 0 and allowed one rising edge to take hold. Each stimulus is then checked in the same half-cycle. The delay sweep drives a fresh key and code on every cycle into a history table and compares each output against the entry N cycles back. The setting-change test checks that the old delay still governs in the half-cycle where `dly_i` changes, and that the new one governs after the next rising edge.

// File: rtl/skg_pkg.sv
package skg_pkg;
  typedef enum logic [1:0] {
    CMP_NONE   = 2'b00,
    CMP_BORDER = 2'b01,
    CMP_RSVD   = 2'b10,
    CMP_CHROMA = 2'b11
  } cmp_mode_e;

  function automatic cmp_mode_e decode_mode(input logic e, input logic f);
    return cmp_mode_e'({e, f});
  endfunction
endpackage

// File: rtl/skg_compare.sv
module skg_compare #(
  parameter int COLOR_W = 12
) (
  input  logic               sup_en_i,
  input  skg_pkg::cmp_mode_e mode_i,
  input  logic               fill_g_i,
  input  logic [COLOR_W-1:0] pix_rgb_i,
  input  logic [COLOR_W-1:0] border_rgb_i,
  input  logic [COLOR_W-1:0] chroma_rgb_i,
  output logic               key_o
);
  import skg_pkg::*;

  logic border_black;
  assign border_black = (border_rgb_i == '0);

  always_comb begin
    unique case (mode_i)
      CMP_CHROMA: key_o = (pix_rgb_i != chroma_rgb_i);
      CMP_BORDER: key_o = border_black ? fill_g_i : (pix_rgb_i != border_rgb_i);
      default:    key_o = fill_g_i; // none and reserved code
    endcase
    if (!sup_en_i) key_o = 1'b1;
  end
endmodule

// File: rtl/skg_trans.sv
module skg_trans #(
  parameter int TRANS_W = 6
) (
  input  logic               trans_en_i,
  input  logic               pix_is_bg_i,
  input  logic [TRANS_W-1:0] pix_trans_i,
  input  logic [TRANS_W-1:0] bg_trans_i,
  output logic [TRANS_W-1:0] trans_o
);
  always_comb begin
    if (!trans_en_i)      trans_o = '0;
    else if (pix_is_bg_i) trans_o = bg_trans_i;
    else                  trans_o = pix_trans_i;
  end
endmodule

// File: rtl/skg_delay.sv
module skg_delay #(
  parameter int          W       = 7,
  parameter int          DEPTH   = 7,
  parameter logic [W-1:0] RST_VAL = '0,
  localparam int         SEL_W   = $clog2(DEPTH + 1),
  localparam int         NTAP    = 2 ** SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [W-1:0]     d_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [W-1:0]     q_o
);
  logic [W-1:0] stg [DEPTH];
  logic [W-1:0] tap [NTAP];

  assign tap[0] = d_i;

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[k] <= RST_VAL;
      else         stg[k] <= (k == 0) ? d_i : stg[(k == 0) ? 0 : k - 1];
    end
  end

  for (genvar t = 1; t < NTAP; t++) begin : g_tap
    if (t <= DEPTH) begin : g_real
      assign tap[t] = stg[t-1];
    end else begin : g_clamp
      assign tap[t] = stg[DEPTH-1];
    end
  end

  assign q_o = tap[sel_i];
endmodule

// File: rtl/sup_key_gen.sv
module sup_key_gen #(
  parameter int COLOR_W = 12,
  parameter int TRANS_W = 6,
  parameter int MAX_DLY = 7,
  parameter int DLY_RST = 1,
  localparam int DLY_W  = $clog2(MAX_DLY + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sup_en_i,
  input  logic               cmp_e_i,
  input  logic               cmp_f_i,
  input  logic               fill_g_i,
  input  logic [COLOR_W-1:0] pix_rgb_i,
  input  logic [COLOR_W-1:0] border_rgb_i,
  input  logic [COLOR_W-1:0] chroma_rgb_i,
  input  logic               trans_en_i,
  input  logic               pix_is_bg_i,
  input  logic [TRANS_W-1:0] pix_trans_i,
  input  logic [TRANS_W-1:0] bg_trans_i,
  input  logic [DLY_W-1:0]   dly_i,
  output logic               key_o,
  output logic [TRANS_W-1:0] trans_o
);
  import skg_pkg::*;

  localparam int PW = TRANS_W + 1;

  logic               key_raw;
  logic [TRANS_W-1:0] trans_raw;
  logic [DLY_W-1:0]   dly_q;
  logic [PW-1:0]      pipe_out;

  skg_compare #(.COLOR_W(COLOR_W)) u_cmp (
    .sup_en_i     (sup_en_i),
    .mode_i       (decode_mode(cmp_e_i, cmp_f_i)),
    .fill_g_i     (fill_g_i),
    .pix_rgb_i    (pix_rgb_i),
    .border_rgb_i (border_rgb_i),
    .chroma_rgb_i (chroma_rgb_i),
    .key_o        (key_raw)
  );

  skg_trans #(.TRANS_W(TRANS_W)) u_trans (
    .trans_en_i  (trans_en_i),
    .pix_is_bg_i (pix_is_bg_i),
    .pix_trans_i (pix_trans_i),
    .bg_trans_i  (bg_trans_i),
    .trans_o     (trans_raw)
  );

  // setting applies from the edge that samples it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dly_q <= DLY_W'(DLY_RST);
    else         dly_q <= dly_i;
  end

  skg_delay #(
    .W       (PW),
    .DEPTH   (MAX_DLY),
    .RST_VAL ({1'b1, {TRANS_W{1'b0}}})
  ) u_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({key_raw, trans_raw}),
    .sel_i  (dly_q),
    .q_o    (pipe_out)
  );

  assign key_o   = pipe_out[PW-1];
  assign trans_o = pipe_out[TRANS_W-1:0];
endmodule

// File: rtl/sup_key_gen_chk.sv
module sup_key_gen_chk #(
  parameter int COLOR_W = 12,
  parameter int TRANS_W = 6,
  parameter int DLY_W   = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sup_en_i,
  input logic               cmp_e_i,
  input logic               cmp_f_i,
  input logic               trans_en_i,
  input logic [COLOR_W-1:0] pix_rgb_i,
  input logic [COLOR_W-1:0] chroma_rgb_i,
  input logic [DLY_W-1:0]   dly_q,
  input logic               key_raw,
  input logic [TRANS_W-1:0] trans_raw,
  input logic               key_o,
  input logic [TRANS_W-1:0] trans_o
);
  logic seen;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen <= 1'b0;
    else         seen <= 1'b1;
  end

  // R1
  bypass_key_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dly_q == '0 && !sup_en_i) |-> key_o);

  // R5
  chroma_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dly_q == '0 && sup_en_i && cmp_e_i && cmp_f_i) |-> (key_o == (pix_rgb_i != chroma_rgb_i)));

  // R6
  trans_off_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dly_q == '0 && !trans_en_i) |-> (trans_o == '0));

  // R8
  one_cycle_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && dly_q == DLY_W'(1)) |-> (key_o == $past(key_raw)));

  // R8
  one_cycle_trans_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && dly_q == DLY_W'(1)) |-> (trans_o == $past(trans_raw)));
endmodule

bind sup_key_gen sup_key_gen_chk #(
  .COLOR_W (COLOR_W),
  .TRANS_W (TRANS_W),
  .DLY_W   (DLY_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sup_en_i     (sup_en_i),
  .cmp_e_i      (cmp_e_i),
  .cmp_f_i      (cmp_f_i),
  .trans_en_i   (trans_en_i),
  .pix_rgb_i    (pix_rgb_i),
  .chroma_rgb_i (chroma_rgb_i),
  .dly_q        (dly_q),
  .key_raw      (key_raw),
  .trans_raw    (trans_raw),
  .key_o        (key_o),
  .trans_o      (trans_o)
);

// File: tb/tb_sup_key_gen.sv
`timescale 1ns/1ps
module tb_sup_key_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sup_en_i, cmp_e_i, cmp_f_i, fill_g_i;
  logic [11:0] pix_rgb_i, border_rgb_i, chroma_rgb_i;
  logic        trans_en_i, pix_is_bg_i;
  logic [5:0]  pix_trans_i, bg_trans_i;
  logic [2:0]  dly_i;
  logic        key_o;
  logic [5:0]  trans_o;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  sup_key_gen dut (.*);

  task automatic chk(input string rq, input int got, input int exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", rq, got, exp);
    end
  endtask

  task automatic set_dly(input logic [2:0] d);
    @(negedge clk_i);
    dly_i = d;
    @(negedge clk_i);
  endtask

  task automatic drive_now();
    @(negedge clk_i);
    #1;
  endtask

  task automatic t_reset();
    sup_en_i = 1; cmp_e_i = 0; cmp_f_i = 0; fill_g_i = 0;
    trans_en_i = 1; pix_is_bg_i = 0; pix_trans_i = 6'h2a; bg_trans_i = 6'h15;
    pix_rgb_i = 12'h123; border_rgb_i = 12'h456; chroma_rgb_i = 12'h789;
    dly_i = 3'd3;
    #12;
    chk("R9 key in reset", key_o, 1);
    chk("R9 trans in reset", trans_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk("R9 key after reset", key_o, 1);
    chk("R9 trans after reset", trans_o, 0);
  endtask

  task automatic t_bypass();
    set_dly(3'd0);
    sup_en_i = 0; cmp_e_i = 1; cmp_f_i = 1; fill_g_i = 0;
    pix_rgb_i = 12'h777; chroma_rgb_i = 12'h777;
    drive_now();
    chk("R1 sup off chroma match", key_o, 1);
    cmp_e_i = 0; cmp_f_i = 0;
    drive_now();
    chk("R1 sup off fill low", key_o, 1);
  endtask

  task automatic t_modes();
    set_dly(3'd0);
    sup_en_i = 1; pix_rgb_i = 12'h0f0; border_rgb_i = 12'h00f; chroma_rgb_i = 12'h0f0;
    for (int g = 0; g < 2; g++) begin
      fill_g_i = g[0];
      cmp_e_i = 0; cmp_f_i = 0; drive_now();
      chk("R2 mode 00", key_o, g);
      cmp_e_i = 1; cmp_f_i = 0; drive_now();
      chk("R2 mode 10", key_o, g);
    end
    cmp_e_i = 0; cmp_f_i = 1; fill_g_i = 0;
    border_rgb_i = 12'h00f; pix_rgb_i = 12'h00f; drive_now();
    chk("R3 border match", key_o, 0);
    pix_rgb_i = 12'h00e; drive_now();
    chk("R3 border differ", key_o, 1);
    border_rgb_i = 12'h000; pix_rgb_i = 12'h5a5; fill_g_i = 0; drive_now();
    chk("R4 black border g0", key_o, 0);
    fill_g_i = 1; pix_rgb_i = 12'h000; drive_now();
    chk("R4 black border g1", key_o, 1);
    cmp_e_i = 1; cmp_f_i = 1; fill_g_i = 0;
    chroma_rgb_i = 12'habc; pix_rgb_i = 12'habc; drive_now();
    chk("R5 chroma match", key_o, 0);
    pix_rgb_i = 12'h2bc; drive_now();
    chk("R5 chroma differ", key_o, 1);
  endtask

  task automatic t_trans();
    set_dly(3'd0);
    trans_en_i = 0; pix_trans_i = 6'h3f; bg_trans_i = 6'h21;
    pix_is_bg_i = 0; drive_now();
    chk("R6 off pixel", trans_o, 0);
    pix_is_bg_i = 1; drive_now();
    chk("R6 off background", trans_o, 0);
    trans_en_i = 1; drive_now();
    chk("R7 background code", trans_o, 6'h21);
    pix_is_bg_i = 0; drive_now();
    chk("R7 pixel code", trans_o, 6'h3f);
  endtask

  task automatic t_delay();
    bit       hk [32];
    bit [5:0] ht [32];
    for (int n = 0; n < 8; n++) begin
      set_dly(3'(n));
      sup_en_i = 1; cmp_e_i = 1; cmp_f_i = 1; chroma_rgb_i = 12'h000;
      trans_en_i = 1; pix_is_bg_i = 0;
      for (int i = 0; i < 32; i++) begin
        @(negedge clk_i);
        hk[i] = ((i * 5 + n) % 3) != 0;
        ht[i] = 6'((i * 7 + n) & 63);
        pix_rgb_i = hk[i] ? 12'h001 : 12'h000;
        pix_trans_i = ht[i];
        #1;
        if (i >= 12 && (i % 4) == 0) begin
          chk($sformatf("R8 key delay %0d", n), key_o, hk[i-n]);
          chk($sformatf("R8 trans delay %0d", n), trans_o, ht[i-n]);
        end
      end
    end
  endtask

  task automatic t_switch();
    set_dly(3'd5);
    sup_en_i = 1; cmp_e_i = 0; cmp_f_i = 0; trans_en_i = 0;
    fill_g_i = 1; drive_now();
    for (int i = 0; i < 8; i++) drive_now();
    fill_g_i = 0;
    @(negedge clk_i);
    dly_i = 3'd0;
    #1;
    chk("R10 old delay holds", key_o, 1);
    @(negedge clk_i);
    #1;
    chk("R10 new delay applies", key_o, 0);
  endtask

  initial begin
    #100000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_bypass();
    t_modes();
    t_trans();
    t_delay();
    t_switch();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule